// File: doc/BRIEF.md
# Biphase Serial Packet Receiver

This block recovers variable-length packets from a single track data line that carries bits as two half-cells each. The raw line first passes through a flop synchroniser. While no packet is in flight, the receiver watches for a rising edge. That edge opens a packet and also counts as the first half-cell of the first bit. From then on, the line is sampled once per half-bit period on an internal grid that counts pulses of the `tick_i` timebase. The grid is restarted at zero by the opening edge.

The value of each bit is the line level in the second half of its cell. High gives 1 and low gives 0. Each bit is shifted into the least significant end of a word. A cell whose two halves both read low closes the packet. The receiver then shows the assembled word and the number of bits on a one-cycle `valid_o` pulse, and it goes back to watching for the next rising edge.

The result is a plain strobe with no back-pressure. The line cannot be stalled, so there is no ready input. A consumer must capture the result on the cycle `valid_o` is high, or read `data_o` and `len_o` at any later time before the next packet completes.

Top module: `biphase_rx`

## Requirements
- R1: After reset, `valid_o` is 0, `data_o` is 0 and `len_o` is 0, and the receiver is idle.
- R2: While idle, a rising edge of the synchronised line starts a packet. Further rising edges have no restart effect until that packet has closed.
- R3: Line samples are taken every HALF_TICKS pulses of `tick_i`, counted from zero at the opening edge. The first sample is the second half of the first bit cell.
- R4: On each second-half sample that does not close the packet, the word shifts left by one. The line level enters bit 0 (high = 1, low = 0).
- R5: A second-half sample that reads low, with the preceding first-half sample also low, closes the packet. It produces exactly one `valid_o` pulse, with `data_o` equal to the word and `len_o` equal to the number of bits received.
- R6: The length counter is LEN_W bits wide and wraps modulo 2^LEN_W. The word keeps only the last DATA_W bits received.
- R7: `valid_o` is high for one cycle per packet. `data_o` and `len_o` change only in a cycle where `valid_o` is high.
- R8: With no rising edge on the line, no `valid_o` is produced. After a packet closes, the next rising edge starts a new packet.
- R9: The opening edge clears the word and the length counter, so a new packet's result does not depend on earlier packets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Raw track data line, asynchronous |
| tick_i | input | 1 | Timebase pulse; HALF_TICKS pulses make one half-bit period |
| data_o | output | DATA_W | Last assembled packet word, bits in arrival order with the newest in bit 0 |
| len_o | output | LEN_W | Bit count of the last packet, modulo 2^LEN_W |
| valid_o | output | 1 | One-cycle strobe marking a new `data_o`/`len_o` |

## Verification
Faults in the internal state all reach the ports on the `valid_o` strobe that closes the affected packet. A sample grid that has drifted or is mis-phased shifts in wrong or extra bits, so `data_o` and `len_o` disagree with the transmitted stream. A half-cell phase tracker that has slipped either closes a packet early or misses its end, so a pulse is missing or extra within one packet time. Stale word contents from a missed clear show up in the upper bits of a short packet's word. Dense random packets with lengths from one to beyond the counter's range, plus an idle stretch, make each of these visible within one packet.

// File: rtl/bpr_pkg.sv
package bpr_pkg;
  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_BUSY = 1'b1
  } rx_state_t;

  typedef enum logic {
    HALF_LEAD  = 1'b0,
    HALF_TRAIL = 1'b1
  } half_t;
endpackage

// File: rtl/bpr_sync.sv
module bpr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/bpr_half_timer.sv
module bpr_half_timer #(
  parameter int HALF_TICKS = 8,
  localparam int CNT_W = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic run_i,
  input  logic tick_i,
  output logic sample_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap     = (cnt_q == LAST);
  assign sample_o = run_i && tick_i && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= '0;
    end else if (run_i && tick_i) begin
      cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R3

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (cnt_q == '0)); // R3
endmodule

// File: rtl/bpr_decoder.sv
module bpr_decoder
  import bpr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_i,
  input  logic              sample_i,
  output logic              start_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] data_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              valid_o
);
  rx_state_t         state_q;
  half_t             half_q;
  logic              line_q;
  logic              lead_low_q;
  logic [DATA_W-1:0] word_q;
  logic [LEN_W-1:0]  bits_q;
  logic              close_now;

  assign start_o   = (state_q == RX_IDLE) && line_i && !line_q;
  assign busy_o    = (state_q == RX_BUSY);
  assign close_now = lead_low_q && !line_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= line_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= RX_IDLE;
      half_q     <= HALF_TRAIL;
      lead_low_q <= 1'b0;
      word_q     <= '0;
      bits_q     <= '0;
      data_o     <= '0;
      len_o      <= '0;
      valid_o    <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      case (state_q)
        RX_IDLE: begin
          if (start_o) begin
            state_q    <= RX_BUSY;
            half_q     <= HALF_TRAIL;
            lead_low_q <= 1'b0;
            word_q     <= '0;
            bits_q     <= '0;
          end
        end
        RX_BUSY: begin
          if (sample_i) begin
            if (half_q == HALF_TRAIL) begin
              if (close_now) begin
                state_q <= RX_IDLE;
                data_o  <= word_q;
                len_o   <= bits_q;
                valid_o <= 1'b1;
              end else begin
                bits_q <= bits_q + LEN_W'(1);
                word_q <= {word_q[DATA_W-2:0], line_i};
                half_q <= HALF_LEAD;
              end
            end else begin
              lead_low_q <= !line_i;
              half_q     <= HALF_TRAIL;
            end
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o); // R7

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(data_o) && $stable(len_o))); // R7

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> (busy_o && word_q == '0 && bits_q == '0)); // R9

  AST_CLOSE_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> !busy_o); // R8

  AST_NO_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !start_o); // R2
endmodule

// File: rtl/biphase_rx.sv
module biphase_rx #(
  parameter int DATA_W      = 16,
  parameter int LEN_W       = 6,
  parameter int HALF_TICKS  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_i,
  input  logic              tick_i,
  output logic [DATA_W-1:0] data_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              valid_o
);
  logic line_s;
  logic start_w;
  logic busy_w;
  logic sample_w;

  bpr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  bpr_half_timer #(.HALF_TICKS(HALF_TICKS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (start_w),
    .run_i     (busy_w),
    .tick_i    (tick_i),
    .sample_o  (sample_w)
  );

  bpr_decoder #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_i   (line_s),
    .sample_i (sample_w),
    .start_o  (start_w),
    .busy_o   (busy_w),
    .data_o   (data_o),
    .len_o    (len_o),
    .valid_o  (valid_o)
  );

  AST_SAMPLE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    sample_w |-> busy_w); // R3

  AST_VALID_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(busy_w)); // R5
endmodule

// File: tb/biphase_rx_tb_top.sv
module biphase_rx_tb_top;
  localparam int HT   = 8;
  localparam int HALF = 2 * HT;  // cycles per half-cell, tick every 2 cycles

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_i = 1'b0;
  logic        tick_i = 1'b0;
  logic [15:0] data_o;
  logic [5:0]  len_o;
  logic        valid_o;

  int checks = 0;
  int fails = 0;
  int vcount = 0;
  int dbl_valid = 0;
  logic [15:0] cap_d = '0;
  logic [5:0]  cap_l = '0;
  logic        prev_v = 1'b0;

  always #5 clk = ~clk;

  biphase_rx #(.HALF_TICKS(HT)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .tick_i(tick_i),
    .data_o(data_o), .len_o(len_o), .valid_o(valid_o)
  );

  always @(negedge clk) tick_i <= ~tick_i;

  always @(negedge clk) begin
    if (rst_n) begin
      if (valid_o) begin
        vcount <= vcount + 1;
        cap_d  <= data_o;
        cap_l  <= len_o;
      end
      if (valid_o && prev_v) dbl_valid <= dbl_valid + 1;
      prev_v <= valid_o;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  function automatic logic [15:0] exp_word(input logic [127:0] b, input int n);
    logic [15:0] w = '0;
    for (int i = 0; i < n; i++) w = {w[14:0], b[i]};
    return w;
  endfunction

  // Cell 0 opens with the rising edge; bit i sits in the second half of cell i.
  task automatic send_packet(input logic [127:0] b, input int n, input string tag);
    int vb;
    logic lvl;
    vb = vcount;
    line_i = 1'b1;
    repeat (HALF - 6) @(negedge clk);
    for (int k = 1; k <= 2 * n + 1; k++) begin
      int c;
      c = k / 2;
      if (k % 2 == 1) lvl = (c < n) ? b[c] : 1'b0;
      else if (c < n) lvl = b[c] ? 1'($urandom_range(0, 1)) : 1'b1;
      else lvl = 1'b0;
      line_i = lvl;
      repeat (HALF) @(negedge clk);
    end
    line_i = 1'b0;
    repeat (30) @(negedge clk);
    chk(vcount == vb + 1, {tag, " R5 one strobe"}, vcount - vb, 1);
    chk(cap_d == exp_word(b, n), {tag, " R3 R4 data"}, cap_d, exp_word(b, n));
    chk(cap_l == 6'(n), {tag, " R6 len"}, cap_l, 6'(n));
    chk(data_o == cap_d && len_o == cap_l && !valid_o, {tag, " R7 held"}, data_o, cap_d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [127:0] b;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(valid_o == 1'b0, "R1 valid", valid_o, 0);
    chk(data_o == '0, "R1 data", data_o, 0);
    chk(len_o == '0, "R1 len", len_o, 0);

    repeat (300) @(negedge clk);
    chk(vcount == 0, "R8 idle no strobe", vcount, 0);

    b = '0; b[0] = 1'b1;
    send_packet(b, 1, "single one");
    b = '0;
    send_packet(b, 1, "single zero R9");
    b = '0;
    for (int i = 0; i < 16; i++) b[i] = i[0];
    send_packet(b, 16, "alternating R2");
    b = '1;
    send_packet(b, 17, "ones truncated");
    b = '0;
    for (int i = 0; i < 70; i++) b[i] = 1'($urandom_range(0, 1));
    send_packet(b, 70, "wrap length");
    b = '0; b[1] = 1'b1;
    send_packet(b, 3, "short after long R9");

    for (int r = 0; r < 20; r++) begin
      int n;
      n = $urandom_range(1, 40);
      b = '0;
      for (int i = 0; i < n; i++) b[i] = 1'($urandom_range(0, 1));
      send_packet(b, n, "random R8");
    end

    chk(dbl_valid == 0, "R7 pulse width", dbl_valid, 0);
    summary();
  end
endmodule